// File: doc/BRIEF.md
# Masked Multi-Address Slave Matcher

This block decides whether a serial-bus slave should answer the address byte that follows a START condition. Software programs four slot registers. Each slot register holds a 7-bit slave address in bits 7:1 and a general-call enable in bit 0. Each slot also has a companion mask register in which a set bit makes the matching address bit don't-care. The bus front end hands over each received address byte on a valid/ready stream. One clock later the block presents a registered verdict: whether any slot matched, which slot won, whether the byte was a general call, and the direction bit.

A received address of all zeros is handled on a separate path. In that case no mask and no stored address is consulted, and a slot counts as hit only when its general-call enable is set. When the surrounding controller runs as bus master, slave addressing is meaningless. Raising the master-mode input blocks new bytes and clears the verdict.

Stream rules: the input side asserts `addr_ready_o` whenever the block is not in master mode. A byte is consumed on any rising clock edge where `addr_valid_i` and `addr_ready_o` are both high. The sender may hold `addr_valid_i` and the byte across cycles of back-pressure. Each edge with both signals high counts as a new acceptance.

Top module: `slv_addr_matcher`

## Requirements
- R1: After reset every slot and mask register reads 0x00, and `match_o`, `match_idx_o`, `gen_call_o` and `rnw_o` are all 0.
- R2: A write with `cfg_we_i` high stores `cfg_wdata_i` into the register chosen by `cfg_sel_i`. Bit 2 selects slot (0) or mask (1), and bits 1:0 give the slot number. `cfg_rdata_o` shows the selected register combinationally, and a write leaves every other register unchanged.
- R3: For a non-zero received address, a mask bit of 1 in mask bits 7:1 makes the matching address bit don't-care.
- R4: For a non-zero received address, every address bit whose mask bit is 0 must equal the stored bit, or that slot does not match.
- R5: A received address of 0000000 hits exactly the slots whose general-call enable (bit 0) is set, whatever their masks and stored addresses. The result then shows `match_o`=1 and `gen_call_o`=1.
- R6: A received address of 0000000 with no general-call enable set anywhere gives `match_o`=0 and `gen_call_o`=0. A non-zero address never sets `gen_call_o`.
- R7: When several slots hit, `match_idx_o` reports the lowest-numbered one. With no hit it reads 0.
- R8: Outputs update on the clock edge that accepts a byte, and not before. They hold their value while no byte is accepted.
- R9: `rnw_o` takes bit 0 of the accepted byte, whether or not a slot matched.
- R10: While `master_mode_i` is high, the next edge clears all four result outputs, and valid bytes are ignored.
- R11: `addr_ready_o` is high exactly when `master_mode_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_mode_i | input | 1 | Controller is bus master; suppresses matching |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select: bit 2 slot/mask, bits 1:0 slot number |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data of the selected register |
| addr_valid_i | input | 1 | Address byte valid |
| addr_ready_o | output | 1 | Block accepts an address byte |
| addr_byte_i | input | 8 | Received address byte: bits 7:1 address, bit 0 direction |
| match_o | output | 1 | Some slot hit the last accepted byte |
| match_idx_o | output | 2 | Winning slot number |
| gen_call_o | output | 1 | Last accepted byte was an enabled general call |
| rnw_o | output | 1 | Direction bit of the last accepted byte |

## Verification
The bench targets overlapping slots, where a design that ignored priority would report slot 2 instead of slot 1. It also checks mask bits placed next to unmasked ones, because an off-by-one mask alignment would accept 0x34 or reject 0x33. The general-call cases set a mask of all ones and clear the enable bits. A design that let masks act on the zero address would then claim a match on slot 0, or report a general call that nobody enabled. Latency is probed between the drive and the accepting edge, which catches a combinational or two-stage verdict. Master mode is probed with a valid byte held high, which catches a design that still updates the result.

// File: rtl/slv_match_pkg.sv
`timescale 1ns/1ps
package slv_match_pkg;
  typedef enum logic {
    SEL_SLOT = 1'b0,
    SEL_MASK = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/sam_cfg_regs.sv
`timescale 1ns/1ps
module sam_cfg_regs
  import slv_match_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_W     = 8,
  parameter int IDX_W     = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  cfg_kind_e                       kind_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [REG_W-1:0]                wdata_i,
  output logic [REG_W-1:0]                rdata_o,
  output logic [NUM_SLOTS-1:0][REG_W-1:0] slot_regs_o,
  output logic [NUM_SLOTS-1:0][REG_W-1:0] mask_regs_o
);
  logic [NUM_SLOTS-1:0][REG_W-1:0] slot_q;
  logic [NUM_SLOTS-1:0][REG_W-1:0] mask_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_reg
    logic sel_hit;
    assign sel_hit = we_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
        mask_q[g] <= '0;
      end else if (sel_hit) begin
        if (kind_i == SEL_SLOT) slot_q[g] <= wdata_i;
        else                    mask_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (idx_i == IDX_W'(i)) begin
        rdata_o = (kind_i == SEL_SLOT) ? slot_q[i] : mask_q[i];
      end
    end
  end

  assign slot_regs_o = slot_q;
  assign mask_regs_o = mask_q;
endmodule

// File: rtl/sam_slot_cmp.sv
`timescale 1ns/1ps
module sam_slot_cmp #(
  parameter int ADDR_W = 7,
  localparam int REG_W = ADDR_W + 1
) (
  input  logic [REG_W-1:0]  slot_reg_i,
  input  logic [REG_W-1:0]  mask_reg_i,
  input  logic [ADDR_W-1:0] rx_addr_i,
  input  logic              rx_is_gc_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] stored;
  logic [ADDR_W-1:0] care;
  logic              gc_en;
  logic              addr_eq;

  assign stored  = slot_reg_i[REG_W-1:1];
  assign gc_en   = slot_reg_i[0];
  assign care    = ~mask_reg_i[REG_W-1:1];
  assign addr_eq = ((rx_addr_i ^ stored) & care) == '0;

  // The zero address bypasses mask and stored address entirely.
  assign hit_o = rx_is_gc_i ? gc_en : addr_eq;
endmodule

// File: rtl/sam_prio_enc.sv
`timescale 1ns/1ps
module sam_prio_enc #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/slv_addr_matcher.sv
`timescale 1ns/1ps
module slv_addr_matcher
  import slv_match_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 7,
  localparam int REG_W    = ADDR_W + 1,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int SEL_W    = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             master_mode_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  input  logic             addr_valid_i,
  output logic             addr_ready_o,
  input  logic [REG_W-1:0] addr_byte_i,
  output logic             match_o,
  output logic [IDX_W-1:0] match_idx_o,
  output logic             gen_call_o,
  output logic             rnw_o
);
  logic [NUM_SLOTS-1:0][REG_W-1:0] slot_regs;
  logic [NUM_SLOTS-1:0][REG_W-1:0] mask_regs;
  logic [NUM_SLOTS-1:0]            hits;
  logic [ADDR_W-1:0]               rx_addr;
  logic                            rx_is_gc;
  logic                            any_hit;
  logic [IDX_W-1:0]                win_idx;
  logic                            accept;
  cfg_kind_e                       cfg_kind;

  assign cfg_kind = cfg_kind_e'(cfg_sel_i[SEL_W-1]);

  sam_cfg_regs #(
    .NUM_SLOTS(NUM_SLOTS),
    .REG_W    (REG_W),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .kind_i     (cfg_kind),
    .idx_i      (cfg_sel_i[IDX_W-1:0]),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .slot_regs_o(slot_regs),
    .mask_regs_o(mask_regs)
  );

  assign rx_addr  = addr_byte_i[REG_W-1:1];
  assign rx_is_gc = (rx_addr == '0);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    sam_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .slot_reg_i(slot_regs[g]),
      .mask_reg_i(mask_regs[g]),
      .rx_addr_i (rx_addr),
      .rx_is_gc_i(rx_is_gc),
      .hit_o     (hits[g])
    );
  end

  sam_prio_enc #(.N(NUM_SLOTS), .IDX_W(IDX_W)) u_prio (
    .req_i(hits),
    .any_o(any_hit),
    .idx_o(win_idx)
  );

  assign addr_ready_o = !master_mode_i;
  assign accept       = addr_valid_i && addr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o     <= 1'b0;
      match_idx_o <= '0;
      gen_call_o  <= 1'b0;
      rnw_o       <= 1'b0;
    end else if (master_mode_i) begin
      match_o     <= 1'b0;
      match_idx_o <= '0;
      gen_call_o  <= 1'b0;
      rnw_o       <= 1'b0;
    end else if (accept) begin
      match_o     <= any_hit;
      match_idx_o <= win_idx;
      gen_call_o  <= rx_is_gc && any_hit;
      rnw_o       <= addr_byte_i[0];
    end
  end
endmodule

// File: rtl/sam_checker.sv
`timescale 1ns/1ps
module sam_checker #(
  parameter int IDX_W = 2,
  parameter int REG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             master_mode_i,
  input logic             addr_valid_i,
  input logic             addr_ready_o,
  input logic [REG_W-1:0] addr_byte_i,
  input logic             match_o,
  input logic [IDX_W-1:0] match_idx_o,
  input logic             gen_call_o,
  input logic             rnw_o
);
  // R8: no acceptance and no master mode keeps the verdict steady
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(addr_valid_i && addr_ready_o) && !master_mode_i)
      |=> $stable({match_o, match_idx_o, gen_call_o, rnw_o}));

  // R10: master mode clears the verdict at the next edge
  a_r10_master_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_mode_i |=> (!match_o && !gen_call_o && !rnw_o && match_idx_o == '0));

  // R9: direction bit follows the accepted byte
  a_r9_rnw_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && addr_ready_o) |=> (rnw_o == $past(addr_byte_i[0])));

  // R5: a general call is always also a match
  a_r5_gc_is_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> match_o);

  // R6: a non-zero accepted address never raises the general-call flag
  a_r6_gc_only_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && addr_ready_o && addr_byte_i[REG_W-1:1] != '0) |=> !gen_call_o);

  // R7: with no match the index rests at zero
  a_r7_idx_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_o |-> (match_idx_o == '0));

  // R11: master mode refuses input
  a_r11_ready_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_mode_i |-> !addr_ready_o);
endmodule

bind slv_addr_matcher sam_checker #(.IDX_W(IDX_W), .REG_W(REG_W)) u_sam_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .master_mode_i(master_mode_i),
  .addr_valid_i (addr_valid_i),
  .addr_ready_o (addr_ready_o),
  .addr_byte_i  (addr_byte_i),
  .match_o      (match_o),
  .match_idx_o  (match_idx_o),
  .gen_call_o   (gen_call_o),
  .rnw_o        (rnw_o)
);

// File: tb/slv_addr_matcher_tb.sv
`timescale 1ns/1ps
module slv_addr_matcher_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       addr_valid = 1'b0;
  logic       addr_ready;
  logic [7:0] addr_byte = '0;
  logic       match;
  logic [1:0] match_idx;
  logic       gen_call;
  logic       rnw;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  slv_addr_matcher dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .master_mode_i(master_mode),
    .cfg_we_i     (cfg_we),
    .cfg_sel_i    (cfg_sel),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_rdata_o  (cfg_rdata),
    .addr_valid_i (addr_valid),
    .addr_ready_o (addr_ready),
    .addr_byte_i  (addr_byte),
    .match_o      (match),
    .match_idx_o  (match_idx),
    .gen_call_o   (gen_call),
    .rnw_o        (rnw)
  );

  // Row: {byte, match, idx, gen_call, rnw}
  // Slots: 0 = 0x2A no GC, 1 = 0x30 GC mask 0x06, 2 = 0x31, 3 = 0x40 GC mask 0x1E
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    {8'h54, 1'b1, 2'd0, 1'b0, 1'b0},  // R4 exact hit
    {8'h55, 1'b1, 2'd0, 1'b0, 1'b1},  // R9 read direction
    {8'h56, 1'b0, 2'd0, 1'b0, 1'b0},  // R4 unmasked bit differs
    {8'h66, 1'b1, 2'd1, 1'b0, 1'b0},  // R3 masked bits
    {8'h62, 1'b1, 2'd1, 1'b0, 1'b0},  // R7 slot 1 over slot 2
    {8'h68, 1'b0, 2'd0, 1'b0, 1'b0},  // R4 bit beside mask
    {8'h9F, 1'b1, 2'd3, 1'b0, 1'b1},  // R3 wide mask
    {8'hA0, 1'b0, 2'd0, 1'b0, 1'b0},  // R4 miss
    {8'h00, 1'b1, 2'd1, 1'b1, 1'b0},  // R5 general call, lowest enabled
    {8'h01, 1'b1, 2'd1, 1'b1, 1'b1},  // R5 general call, read
    {8'hFE, 1'b0, 2'd0, 1'b0, 1'b0}   // R6 all ones, no GC flag
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic chk_res(input string tag, input logic m, input logic [1:0] i,
                         input logic g, input logic r);
    chk(tag, {3'b0, match, match_idx, gen_call, rnw}, {3'b0, m, i, g, r});
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [2:0] sel, input logic [7:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    addr_valid = 1'b1; addr_byte = b;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk_res("R1 outputs after reset", 1'b0, 2'd0, 1'b0, 1'b0);
    for (int s = 0; s < 8; s++) rd("R1 register reset value", 3'(s), 8'h00);
    rst_n = 1'b1;
    // R11: ready follows master mode
    @(negedge clk);
    chk("R11 ready when slave", {7'b0, addr_ready}, 8'h01);

    // R2: configuration writes and readback (bit2 = mask, bits1:0 = slot)
    wr(3'b000, 8'h54); wr(3'b001, 8'h61); wr(3'b010, 8'h62); wr(3'b011, 8'h81);
    wr(3'b101, 8'h06); wr(3'b111, 8'h1E);
    rd("R2 slot0", 3'b000, 8'h54); rd("R2 slot1", 3'b001, 8'h61);
    rd("R2 slot2", 3'b010, 8'h62); rd("R2 slot3", 3'b011, 8'h81);
    rd("R2 mask0 untouched", 3'b100, 8'h00); rd("R2 mask1", 3'b101, 8'h06);
    rd("R2 mask2 untouched", 3'b110, 8'h00); rd("R2 mask3", 3'b111, 8'h1E);

    // Table walk: R3 R4 R5 R6 R7 R9
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][12:5]);
      chk_res($sformatf("table row %0d (R3/R4 R5 R6 R7 R9)", v),
              VEC[v][4], VEC[v][3:2], VEC[v][1], VEC[v][0]);
    end

    // R8: nothing changes before the accepting edge, then holds while idle
    @(negedge clk);
    addr_valid = 1'b1; addr_byte = 8'h9F;
    #5;
    chk_res("R8 before accepting edge", 1'b0, 2'd0, 1'b0, 1'b0);
    @(negedge clk);
    addr_valid = 1'b0; addr_byte = 8'h00;
    chk_res("R8 after accepting edge", 1'b1, 2'd3, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk_res("R8 held while idle", 1'b1, 2'd3, 1'b0, 1'b1);

    // R5: masks ignored for the zero address; mask0 all don't-care
    wr(3'b100, 8'hFE);
    send(8'h00);
    chk_res("R5 mask ignored on general call", 1'b1, 2'd1, 1'b1, 1'b0);
    send(8'h02);
    chk_res("R3 all bits don't-care", 1'b1, 2'd0, 1'b0, 1'b0);

    // R6: no general-call enable anywhere
    wr(3'b001, 8'h60); wr(3'b011, 8'h80);
    send(8'h00);
    chk_res("R6 zero address without enable", 1'b0, 2'd0, 1'b0, 1'b0);

    // R7: only slot 3 enabled for general call
    wr(3'b011, 8'h81);
    send(8'h01);
    chk_res("R7 general call lone slot 3", 1'b1, 2'd3, 1'b1, 1'b1);

    // R10: master mode clears and blocks
    @(negedge clk);
    master_mode = 1'b1; addr_valid = 1'b1; addr_byte = 8'h54;
    #1;
    chk("R11 ready low in master mode", {7'b0, addr_ready}, 8'h00);
    @(negedge clk);
    chk_res("R10 cleared in master mode", 1'b0, 2'd0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk_res("R10 valid byte ignored", 1'b0, 2'd0, 1'b0, 1'b0);
    master_mode = 1'b0; addr_valid = 1'b0;
    @(negedge clk);
    chk_res("R10 still clear after leaving", 1'b0, 2'd0, 1'b0, 1'b0);
    send(8'h54);
    chk_res("R10 matching resumes", 1'b1, 2'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule